// File: doc/BRIEF.md
# I2C Master Line Sequencer with Bus Recovery

This block is the lowest layer of an I2C master. It takes one command at a time and turns it into a timed pattern on the open-drain clock and data wires. The commands are: a nine-pulse bus recovery, a START condition, a STOP condition, a byte write, and a byte read that ends with a chosen acknowledge level. Each wire is controlled by an output enable. When the enable is asserted, the wire is pulled low. When it is clear, the wire is released and floats high. The data wire is sampled through a single input.

All timing is built from a quarter-bit interval. One quarter lasts `quarter_div + 1` system clocks, and the divider can be changed at run time between commands. Every phase of every command lasts a whole number of quarters. When a command finishes, the block gives a one-clock completion strobe. After a read, the assembled byte is held on `rx_byte`. After a write, the acknowledge level the target drove is held on `ack_seen`. Transaction framing is left to the logic above: addressing, retries, and the order of commands. So are clock stretching and arbitration.

Top module: `i2c_line_seq`

## Requirements
- R1: A synchronous reset releases both wires and leaves the block idle. After reset `scl_oe`, `sda_oe`, `busy`, `done`, `rx_byte` and `ack_seen` are all 0.
- R2: A quarter lasts `quarter_div + 1` clocks. A command accepted at clock edge E, with Q quarters, has its quarter n starting at edge E + n·(quarter_div+1). It finishes at edge E + Q·(quarter_div+1).
- R3: A START (`cmd_op` = 1) lasts 4 quarters:
  - first quarter: both wires keep their previous state;
  - second quarter: data released;
  - third quarter: clock released;
  - fourth quarter: data pulled low.
- R4: A STOP (`cmd_op` = 2) lasts 4 quarters and leaves both wires released:
  - first quarter: clock pulled, data unchanged;
  - second quarter: both pulled;
  - third quarter: clock released;
  - fourth quarter: data released.
- R5: A write (`cmd_op` = 3) sends `cmd_wdata` most significant bit first. Each bit takes 4 quarters:
  - first quarter: clock pulled, data unchanged;
  - second quarter: data shows the bit (1 = released, 0 = pulled);
  - third and fourth quarters: clock released.
- R6: After the eighth written bit there is a 5-quarter acknowledge slot:
  - first quarter: clock pulled;
  - second quarter: data released;
  - third and fourth quarters: clock released;
  - fifth quarter: clock pulled.

  `sda_in` is sampled at the end of the fourth slot quarter into `ack_seen` (0 = acknowledged).
- R7: A read (`cmd_op` = 4) releases data. Each of its 8 bits takes 3 quarters: clock pulled, then clock released, then clock released. `sda_in` is sampled at the end of the second quarter. The bits are assembled most significant first into `rx_byte`.
- R8: After a read there is a 5-quarter acknowledge slot:
  - first quarter: clock pulled;
  - second quarter: data driven to `cmd_nack` (0 = pulled, meaning ACK; 1 = released, meaning NACK);
  - third and fourth quarters: clock released;
  - fifth quarter: clock pulled.
- R9: A recovery (`cmd_op` = 0) releases data and gives 9 clock pulses, each pulled for 2 quarters and released for 2. It then performs the R4 STOP, for 40 quarters in total.
- R10: While `busy` is 1, `cmd_valid` has no effect. `cmd_op` codes 5 to 7 are never accepted.
- R11: `busy` is 1 from the edge that accepts a command to the edge that finishes it. At the finishing edge `done` goes to 1 for exactly one clock and `busy` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| quarter_div | input | DIV_W | Quarter length minus one, in clocks |
| cmd_valid | input | 1 | Command request, taken only when idle |
| cmd_op | input | 3 | 0 recovery, 1 START, 2 STOP, 3 write, 4 read |
| cmd_wdata | input | DATA_W | Byte to write |
| cmd_nack | input | 1 | Acknowledge level to send after a read |
| sda_in | input | 1 | Sampled level of the data wire |
| scl_oe | output | 1 | Clock wire pull-low enable |
| sda_oe | output | 1 | Data wire pull-low enable |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock completion strobe |
| rx_byte | output | DATA_W | Last byte read |
| ack_seen | output | 1 | Acknowledge level sampled after the last write |

## Verification
The assertions assume three things about the inputs:
- `sda_in` is a clean level synchronous to `clk`, already resolved from the wired-AND of the master and target pulls.
- `quarter_div` holds still while a command runs.
- Requests made while busy are meant to be dropped.

The bench keeps within these. It builds `sda_in` on the same clock from the block's own data enable and a modelled target pull. It changes the divider only between commands. It raises `cmd_valid` in the middle of a running write, to confirm that the request is dropped rather than queued.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_STOP,
    S_WBIT,
    S_WACK,
    S_RBIT,
    S_RACK,
    S_PULSE
  } st_e;

  typedef enum logic [1:0] {
    LN_KEEP,
    LN_PULL,
    LN_REL
  } ln_e;

  typedef struct packed {
    ln_e scl;
    ln_e sda;
  } act_t;

  localparam int PH_W = 3;

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick); // R2

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PULSES = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [DATA_W-1:0]     cmd_wdata,
  input  logic                  cmd_nack,
  input  logic                  sda_in,
  output st_e                   st,
  output st_e                   nst,
  output logic [PH_W-1:0]       nph,
  output logic                  load,
  output logic                  drv_bit,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     rx_byte,
  output logic                  ack_seen
);

  localparam int MAXC  = (PULSES > DATA_W) ? PULSES : DATA_W;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(PULSES - 1);

  logic [PH_W-1:0]   ph;
  logic [CNT_W-1:0]  bitn, nbit;
  logic [DATA_W-1:0] tx;
  logic              nack_q, accept, fin;
  st_e               op_st;

  always_comb begin
    unique case (cmd_op)
      OP_RECOVER: op_st = S_PULSE;
      OP_START:   op_st = S_START;
      OP_STOP:    op_st = S_STOP;
      OP_WRITE:   op_st = S_WBIT;
      OP_READ:    op_st = S_RBIT;
      default:    op_st = S_IDLE;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign accept  = !busy && cmd_valid && (op_st != S_IDLE);
  assign load    = accept || tick;
  assign drv_bit = (nst == S_RACK) ? nack_q : tx[DATA_W-1];

  always_comb begin
    nst = st;
    nph = ph + 1'b1;
    nbit = bitn;
    fin = 1'b0;
    if (accept) begin
      nst = op_st; nph = '0; nbit = '0;
    end else if (tick) begin
      unique case (st)
        S_START, S_STOP: if (ph == 3'd3) fin = 1'b1;
        S_WBIT: if (ph == 3'd3) begin
          nph = '0;
          if (bitn == LAST_BIT) begin nst = S_WACK; nbit = '0; end
          else nbit = bitn + 1'b1;
        end
        S_RBIT: if (ph == 3'd2) begin
          nph = '0;
          if (bitn == LAST_BIT) begin nst = S_RACK; nbit = '0; end
          else nbit = bitn + 1'b1;
        end
        S_WACK, S_RACK: if (ph == 3'd4) fin = 1'b1;
        S_PULSE: if (ph == 3'd3) begin
          nph = '0;
          if (bitn == LAST_PULSE) begin nst = S_STOP; nbit = '0; end
          else nbit = bitn + 1'b1;
        end
        default: ;
      endcase
      if (fin) begin nst = S_IDLE; nph = '0; end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; tx <= '0; nack_q <= 1'b0;
      rx_byte <= '0; ack_seen <= 1'b0; done <= 1'b0;
    end else begin
      done <= fin;
      if (load) begin st <= nst; ph <= nph; bitn <= nbit; end
      if (accept) begin tx <= cmd_wdata; nack_q <= cmd_nack; end
      if (tick && st == S_WBIT && ph == 3'd3) tx <= tx << 1;
      if (tick && st == S_RBIT && ph == 3'd1) rx_byte <= {rx_byte[DATA_W-2:0], sda_in};
      if (tick && st == S_WACK && ph == 3'd3) ack_seen <= sda_in;
    end
  end

  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && !tick) |=> $stable(st)); // R10

endmodule

// File: rtl/i2c_line_drv.sv
module i2c_line_drv
  import i2c_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  st_e             nst,
  input  logic [PH_W-1:0] nph,
  input  logic            drv_bit,
  output logic            scl_oe,
  output logic            sda_oe
);

  act_t a;
  ln_e  bit_ln;

  assign bit_ln = drv_bit ? LN_REL : LN_PULL;

  always_comb begin
    a = '{scl: LN_KEEP, sda: LN_KEEP};
    unique case (nst)
      S_START: case (nph)
        3'd1: a.sda = LN_REL;
        3'd2: a.scl = LN_REL;
        3'd3: a.sda = LN_PULL;
        default: ;
      endcase
      S_STOP: case (nph)
        3'd0: a.scl = LN_PULL;
        3'd1: a.sda = LN_PULL;
        3'd2: a.scl = LN_REL;
        3'd3: a.sda = LN_REL;
        default: ;
      endcase
      S_WBIT, S_WACK, S_RACK: case (nph)
        3'd0: a.scl = LN_PULL;
        3'd1: a.sda = (nst == S_WACK) ? LN_REL : bit_ln;
        3'd2: a.scl = LN_REL;
        3'd4: a.scl = LN_PULL;
        default: ;
      endcase
      S_RBIT, S_PULSE: case (nph)
        3'd0: begin a.scl = LN_PULL; a.sda = LN_REL; end
        3'd1: if (nst == S_RBIT) a.scl = LN_REL;
        3'd2: a.scl = LN_REL;
        default: ;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (load) begin
      if (a.scl == LN_PULL) scl_oe <= 1'b1;
      else if (a.scl == LN_REL) scl_oe <= 1'b0;
      if (a.sda == LN_PULL) sda_oe <= 1'b1;
      else if (a.sda == LN_REL) sda_oe <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_line_seq.sv
module i2c_line_seq
  import i2c_seq_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int PULSES = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  quarter_div,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_nack,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_seen
);

  st_e             st, nst;
  logic [PH_W-1:0] nph;
  logic            tick, load, drv_bit;

  i2c_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .div(quarter_div), .tick(tick)
  );

  i2c_seq_fsm #(.DATA_W(DATA_W), .PULSES(PULSES)) u_fsm (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .sda_in(sda_in),
    .st(st), .nst(nst), .nph(nph), .load(load), .drv_bit(drv_bit),
    .busy(busy), .done(done), .rx_byte(rx_byte), .ack_seen(ack_seen)
  );

  i2c_line_drv u_drv (
    .clk(clk), .rst(rst), .load(load), .nst(nst), .nph(nph),
    .drv_bit(drv_bit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && (st == S_WBIT || st == S_RBIT || st == S_WACK || st == S_RACK))
      |-> scl_oe); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (done && $past(st) == S_STOP) |-> (!scl_oe && !sda_oe)); // R4

endmodule

// File: tb/sim_i2c_line_seq.sv
module sim_i2c_line_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] quarter_div = 16'd3;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_nack = 1'b0;
  logic       slave_pull = 1'b0;
  logic       sda_in;
  logic       scl_oe, sda_oe, busy, done, ack_seen;
  logic [7:0] rx_byte;

  int checks = 0;
  int errors = 0;
  int exp_scl [0:63];
  int exp_sda [0:63];
  int nq = 0;
  int cur_s = 0;
  int cur_d = 0;
  bit finished = 0;

  assign sda_in = !sda_oe && !slave_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_line_seq u0 (
    .clk(clk), .rst(rst), .quarter_div(quarter_div), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .rx_byte(rx_byte), .ack_seen(ack_seen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic q(input int s, input int d);
    exp_scl[nq] = s; exp_sda[nq] = d; nq++; cur_s = s; cur_d = d;
  endtask

  task automatic b_start(); // R3
    nq = 0; q(cur_s, cur_d); q(cur_s, 0); q(0, 0); q(0, 1);
  endtask

  task automatic b_stop_tail(); // R4
    q(1, cur_d); q(1, 1); q(0, 1); q(0, 0);
  endtask

  task automatic b_write(input logic [7:0] b); // R5 R6
    nq = 0;
    for (int i = 7; i >= 0; i--) begin
      q(1, cur_d); q(1, b[i] ? 0 : 1); q(0, cur_d); q(0, cur_d);
    end
    q(1, cur_d); q(1, 0); q(0, 0); q(0, 0); q(1, 0);
  endtask

  task automatic b_read(input bit nack); // R7 R8
    nq = 0;
    for (int i = 0; i < 8; i++) begin
      q(1, 0); q(0, 0); q(0, 0);
    end
    q(1, 0); q(1, nack ? 0 : 1); q(0, cur_d); q(0, cur_d); q(1, cur_d);
  endtask

  task automatic b_recover(); // R9
    nq = 0;
    for (int i = 0; i < 9; i++) begin
      q(1, 0); q(1, 0); q(0, 0); q(0, 0);
    end
    b_stop_tail();
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] wd, input bit nack,
                     input logic [7:0] sdata, input bit inject, input string req);
    int p;
    p = int'(quarter_div) + 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_nack = nack;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < nq; k++) begin
      if (k > 0) repeat (p) @(negedge clk);
      if (op == 3'd4) slave_pull = (k < 24 && k % 3 == 0) ? !sdata[7 - k/3] :
                                   (k < 24 ? slave_pull : 1'b0);
      if (inject && k == 6) begin cmd_valid = 1'b1; cmd_op = 3'd1; end // R10
      if (inject && k == 7) cmd_valid = 1'b0;
      chk(scl_oe == exp_scl[k][0] && sda_oe == exp_sda[k][0] && busy && !done,
          $sformatf("%s R2 quarter %0d", req, k),
          {scl_oe, sda_oe, busy, done}, {exp_scl[k][0], exp_sda[k][0], 2'b10});
    end
    repeat (p) @(negedge clk);
    chk(done && !busy, "R11 done at end", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R11 done one clock", done, 0);
  endtask

  initial begin
    int lim;
    lim = 0;
    while (!finished) begin
      @(posedge clk);
      lim++;
      if (lim > WATCHDOG && !finished) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done && rx_byte == 0 && !ack_seen,
        "R1 reset state", {scl_oe, sda_oe, busy, done, ack_seen}, 0);

    // R9 recovery from released lines
    cur_s = 0; cur_d = 0;
    b_recover(); run(3'd0, 8'h00, 1'b0, 8'h00, 1'b0, "R9 recovery");
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);

    // R10 illegal opcode is not accepted
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd6;
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !scl_oe && !sda_oe, "R10 illegal opcode", {busy, done}, 0);

    b_start(); run(3'd1, 8'h00, 1'b0, 8'h00, 1'b0, "R3 start");

    slave_pull = 1'b1;
    b_write(8'hA5); run(3'd3, 8'hA5, 1'b0, 8'h00, 1'b1, "R5 write A5 inject");
    chk(ack_seen == 1'b0, "R6 ack low seen", ack_seen, 0);
    slave_pull = 1'b0;
    b_write(8'h3C); run(3'd3, 8'h3C, 1'b0, 8'h00, 1'b0, "R5 write 3C");
    chk(ack_seen == 1'b1, "R6 nack seen", ack_seen, 1);

    b_read(1'b0); run(3'd4, 8'h00, 1'b0, 8'h96, 1'b0, "R8 read ack");
    chk(rx_byte == 8'h96, "R7 read 96", rx_byte, 8'h96);
    b_read(1'b1); run(3'd4, 8'h00, 1'b1, 8'h5A, 1'b0, "R8 read nack");
    chk(rx_byte == 8'h5A, "R7 read 5A", rx_byte, 8'h5A);

    nq = 0; b_stop_tail(); run(3'd2, 8'h00, 1'b0, 8'h00, 1'b0, "R4 stop");
    chk(!scl_oe && !sda_oe, "R4 released", {scl_oe, sda_oe}, 0);

    // R2 other divider values, changed while idle
    quarter_div = 16'd6;
    b_start(); run(3'd1, 8'h00, 1'b0, 8'h00, 1'b0, "R2 div6 start");
    b_read(1'b1); run(3'd4, 8'h00, 1'b1, 8'hC3, 1'b0, "R2 div6 read");
    chk(rx_byte == 8'hC3, "R7 div6 read", rx_byte, 8'hC3);

    // R5 R6 R7 sweep every byte with a one-clock quarter
    quarter_div = 16'd0;
    for (int v = 0; v < 256; v++) begin
      slave_pull = v[0];
      b_write(8'(v)); run(3'd3, 8'(v), 1'b0, 8'h00, 1'b0, "R5 sweep write");
      chk(ack_seen == !v[0], "R6 sweep ack", ack_seen, !v[0]);
      slave_pull = 1'b0;
      b_read(v[1]); run(3'd4, 8'h00, v[1], 8'(255 - v), 1'b0, "R8 sweep read");
      chk(rx_byte == 8'(255 - v), "R7 sweep read", rx_byte, 255 - v);
    end

    nq = 0; b_stop_tail(); run(3'd2, 8'h00, 1'b0, 8'h00, 1'b0, "R4 final stop");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule